// File: doc/BRIEF.md
# SMBus Master Transaction Sequencer

This block is the master-side control engine of a two-wire serial bus controller. It turns the controller's register-level actions into commands for a byte-level bus agent. Those actions are start and stop requests, writes and reads of the data register, clearing of the negative-acknowledge flag and clearing of the stall flag. The block also keeps the master status flags that software polls. It handles start and repeated start, and it reads the first data byte written in a transfer as the address byte. It sends bytes with acknowledge checking, triggers receives, and holds a stop request back until a safe point in the transfer.

The bus agent receives one-cycle command pulses: address, send byte, receive byte and end transfer. It answers each one with a one-cycle response carrying an acknowledge flag and, for a receive, the data byte. Only one command is outstanding at a time. While the block waits for a response, it ignores all register events. A stop requested while receiving takes effect at the next data read. A stop requested after a rejected byte takes effect when software acknowledges the NACK. When stall-after-address is enabled, a read transfer does not start receiving until software clears the stall flag.

Top module: `smb_seq_top`

## Requirements
- R1: After reset every status flag is 0, `cmd_valid_o` is 0 and the sequencer is idle.
- R2: A start request succeeds when `bus_busy_i` is 0, or when the sequencer already owns the bus (any state other than idle). On the next cycle mode, transmit, data-ready, busy and bus-held are 1.
- R3: A start request in the idle state with `bus_busy_i` at 1 fails. On the next cycle bus-error is 1, mode and busy are 0, and bus-held is 1.
- R4: In master mode, a data write in the idle state issues an address command (`cmd_op_o` = 0) that carries the written byte. Bit 0 of the byte set means read; bits 7:1 are the target address.
- R5: A NACK response to an address or send command clears data-ready and sets negative-acknowledge. The transmit flag ends up 0 for a read address and 1 otherwise.
- R6: An acknowledged address clears negative-acknowledge. For a write it sets transmit and data-ready. For a read it clears transmit and, unless stalled, issues a receive command (`cmd_op_o` = 2). The byte in that receive's response appears on `rx_data_o` with data-ready set.
- R7: With `stall_en_i` set, an acknowledged address sets the stall flag and issues no receive. Clearing the stall flag in the receiving state issues the receive.
- R8: A stop request while receiving issues no command. Execution then waits for the next data read, or, with `fifo_en_i` set, for the data read at which `fifo_cnt_i` is at most 1.
- R9: A stop request while a NACK is pending issues no command. It executes when the NACK flag is cleared.
- R10: Executing a stop issues an end command (`cmd_op_o` = 3). Its response clears all status flags, sets end-of-busy and returns to idle. A stop request while mode is 0 has no effect.
- R11: A data write in any state other than idle or sending issues no command.
- R12: A send command (`cmd_op_o` = 1) clears data-ready, and an acknowledged response sets it again. Every event is ignored while a command is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request strobe |
| stop_i | input | 1 | Stop request strobe |
| data_wr_i | input | 1 | Data register write event |
| wdata_i | input | DW | Written data byte |
| data_rd_i | input | 1 | Data register read event |
| nack_clr_i | input | 1 | Software clears the NACK flag |
| stall_clr_i | input | 1 | Software clears the stall flag |
| stall_en_i | input | 1 | Stall after an accepted address |
| fifo_en_i | input | 1 | Receive FIFO mode |
| fifo_cnt_i | input | CW | Bytes held in the receive FIFO |
| bus_busy_i | input | 1 | Bus held by another master |
| cmd_valid_o | output | 1 | Agent command pulse |
| cmd_op_o | output | 2 | 0 address, 1 send, 2 receive, 3 end |
| cmd_byte_o | output | DW | Address or data byte |
| rsp_valid_i | input | 1 | Agent response pulse |
| rsp_nack_i | input | 1 | Response was not acknowledged |
| rsp_data_i | input | DW | Received byte |
| rx_data_o | output | DW | Last received byte |
| mode_o | output | 1 | Master mode |
| xmit_o | output | 1 | Transmit direction |
| data_rdy_o | output | 1 | Data register ready |
| nack_o | output | 1 | Negative acknowledge |
| ber_o | output | 1 | Bus error |
| busy_o | output | 1 | Controller busy |
| bus_held_o | output | 1 | Bus held |
| end_busy_o | output | 1 | End of busy period |
| stall_o | output | 1 | Stalled after address |

## Verification
The assertions assume the agent never answers in the same cycle as its command pulse, and that it answers only while a command is outstanding. They also assume software raises at most one event strobe in any cycle. The directed tasks respond at least one cycle after each pulse, raise one strobe at a time, and deliberately raise a stop strobe while a command is outstanding to show that it is ignored.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RECV, ST_NACK, ST_STOP_RX, ST_STOP_NACK
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_ADDR = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_END = 2'd3
  } agent_op_e;

  typedef struct packed {
    logic mode;
    logic xmit;
    logic rdy;
    logic nack;
    logic ber;
    logic busy;
    logic held;
    logic eob;
    logic stall;
  } flag_t;

  localparam int unsigned FLAG_W = $bits(flag_t);
endpackage

// File: rtl/smb_seq_flags.sv
module smb_seq_flags
  import smb_seq_pkg::*;
#(
  parameter int unsigned FW = FLAG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] set_i,
  input  logic [FW-1:0] clr_i,
  output logic [FW-1:0] q_o
);
  logic [FW-1:0] q;

  // set wins over clear in the same cycle
  for (genvar i = 0; i < FW; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end

  assign q_o = q;

  flag_t q_s;
  assign q_s = flag_t'(q);

  // R10
  eob_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_s.eob) |-> (!q_s.mode && !q_s.busy && !q_s.nack));

  // R5
  nack_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_s.nack) |-> !q_s.rdy);
endmodule

// File: rtl/smb_seq_ctrl.sv
module smb_seq_ctrl
  import smb_seq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          data_rd_i,
  input  logic          nack_clr_i,
  input  logic          stall_clr_i,
  input  logic          stall_en_i,
  input  logic          fifo_en_i,
  input  logic [CW-1:0] fifo_cnt_i,
  input  logic          bus_busy_i,
  input  flag_t         flags_i,
  output flag_t         set_o,
  output flag_t         clr_o,
  output logic          cmd_valid_o,
  output logic [1:0]    cmd_op_o,
  output logic [DW-1:0] cmd_byte_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_nack_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic [DW-1:0] rx_data_o
);
  seq_state_e    state_q, state_d;
  agent_op_e     op_q, op_d, issue_op;
  logic          wait_q, wait_d;
  logic          rd_q, rd_d;
  logic          cmd_valid_q;
  agent_op_e     cmd_op_q;
  logic [DW-1:0] cmd_byte_q, issue_byte;
  logic [DW-1:0] rx_q, rx_d;
  logic          issue, exec_stop, owned;

  assign owned = (state_q != ST_IDLE);

  always_comb begin
    state_d    = state_q;
    wait_d     = wait_q;
    op_d       = op_q;
    rd_d       = rd_q;
    rx_d       = rx_q;
    issue      = 1'b0;
    issue_op   = OP_END;
    issue_byte = cmd_byte_q;
    exec_stop  = 1'b0;
    set_o      = '0;
    clr_o      = '0;

    if (wait_q) begin
      if (rsp_valid_i) begin
        wait_d = 1'b0;
        unique case (op_q)
          OP_ADDR: begin
            if (rd_q) clr_o.xmit = 1'b1;
            else      set_o.xmit = 1'b1;
            if (rsp_nack_i) begin
              clr_o.rdy  = 1'b1;
              set_o.nack = 1'b1;
              state_d    = ST_NACK;
            end else begin
              clr_o.nack = 1'b1;
              state_d    = rd_q ? ST_RECV : ST_SEND;
              if (stall_en_i) begin
                set_o.stall = 1'b1;
                if (!rd_q) set_o.rdy = 1'b1;
              end else if (rd_q) begin
                clr_o.rdy = 1'b1;
                issue     = 1'b1;
                issue_op  = OP_RECV;
              end else begin
                set_o.rdy = 1'b1;
              end
            end
          end
          OP_SEND: begin
            if (rsp_nack_i) begin
              clr_o.rdy  = 1'b1;
              set_o.nack = 1'b1;
              set_o.xmit = 1'b1;
              state_d    = ST_NACK;
            end else begin
              set_o.rdy = 1'b1;
            end
          end
          OP_RECV: begin
            rx_d      = rsp_data_i;
            set_o.rdy = 1'b1;
          end
          OP_END: begin
            clr_o     = '1;
            set_o.eob = 1'b1;
            state_d   = ST_IDLE;
          end
          default: ;
        endcase
      end
    end else if (start_i) begin
      if (!bus_busy_i || owned) begin
        set_o.mode = 1'b1;
        set_o.xmit = 1'b1;
        set_o.rdy  = 1'b1;
        set_o.busy = 1'b1;
      end else begin
        clr_o.mode = 1'b1;
        clr_o.busy = 1'b1;
        set_o.ber  = 1'b1;
      end
      set_o.held = 1'b1;
      state_d    = ST_IDLE;
    end else if (stop_i) begin
      if (flags_i.mode) begin
        unique case (state_q)
          ST_RECV, ST_STOP_RX: state_d = ST_STOP_RX;
          ST_NACK:             state_d = ST_STOP_NACK;
          default:             exec_stop = 1'b1;
        endcase
      end
    end else if (data_wr_i) begin
      if (flags_i.mode) begin
        if (state_q == ST_IDLE) begin
          issue      = 1'b1;
          issue_op   = OP_ADDR;
          issue_byte = wdata_i;
          rd_d       = wdata_i[0];
        end else if (state_q == ST_SEND) begin
          issue      = 1'b1;
          issue_op   = OP_SEND;
          issue_byte = wdata_i;
          clr_o.rdy  = 1'b1;
        end
      end
    end else if (data_rd_i) begin
      if (state_q == ST_RECV && !fifo_en_i) begin
        clr_o.rdy = 1'b1;
        issue     = 1'b1;
        issue_op  = OP_RECV;
      end else if (state_q == ST_STOP_RX) begin
        if (!fifo_en_i || fifo_cnt_i <= CW'(1)) exec_stop = 1'b1;
      end
    end else if (nack_clr_i) begin
      clr_o.nack = 1'b1;
      if (state_q == ST_STOP_NACK) exec_stop = 1'b1;
    end else if (stall_clr_i) begin
      clr_o.stall = 1'b1;
      if (state_q == ST_RECV && flags_i.stall) begin
        issue    = 1'b1;
        issue_op = OP_RECV;
      end
    end

    if (exec_stop) begin
      issue    = 1'b1;
      issue_op = OP_END;
    end
    if (issue) begin
      wait_d = 1'b1;
      op_d   = issue_op;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wait_q      <= 1'b0;
      op_q        <= OP_END;
      rd_q        <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= OP_END;
      cmd_byte_q  <= '0;
      rx_q        <= '0;
    end else begin
      state_q     <= state_d;
      wait_q      <= wait_d;
      op_q        <= op_d;
      rd_q        <= rd_d;
      rx_q        <= rx_d;
      cmd_valid_q <= issue;
      if (issue) begin
        cmd_op_q   <= issue_op;
        cmd_byte_q <= issue_byte;
      end
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = cmd_op_q;
  assign cmd_byte_o  = cmd_byte_q;
  assign rx_data_o   = rx_q;

  // R3
  start_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && start_i && bus_busy_i && state_q == ST_IDLE)
      |=> (flags_i.ber && !flags_i.mode && flags_i.held));

  // R8
  stop_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && !start_i && stop_i && flags_i.mode && state_q == ST_RECV)
      |=> (state_q == ST_STOP_RX && !cmd_valid_o));

  // R11
  wr_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && !start_i && !stop_i && data_wr_i &&
     state_q != ST_IDLE && state_q != ST_SEND) |=> !cmd_valid_o);

  // R12
  hold_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && !rsp_valid_i) |=> (!cmd_valid_o && $stable(state_q)));
endmodule

// File: rtl/smb_seq_top.sv
module smb_seq_top
  import smb_seq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          data_rd_i,
  input  logic          nack_clr_i,
  input  logic          stall_clr_i,
  input  logic          stall_en_i,
  input  logic          fifo_en_i,
  input  logic [CW-1:0] fifo_cnt_i,
  input  logic          bus_busy_i,
  output logic          cmd_valid_o,
  output logic [1:0]    cmd_op_o,
  output logic [DW-1:0] cmd_byte_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_nack_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic [DW-1:0] rx_data_o,
  output logic          mode_o,
  output logic          xmit_o,
  output logic          data_rdy_o,
  output logic          nack_o,
  output logic          ber_o,
  output logic          busy_o,
  output logic          bus_held_o,
  output logic          end_busy_o,
  output logic          stall_o
);
  flag_t             flag_set, flag_clr, flags;
  logic [FLAG_W-1:0] flag_vec;

  smb_seq_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .data_wr_i, .wdata_i, .data_rd_i,
    .nack_clr_i, .stall_clr_i, .stall_en_i, .fifo_en_i, .fifo_cnt_i,
    .bus_busy_i,
    .flags_i    (flags),
    .set_o      (flag_set),
    .clr_o      (flag_clr),
    .cmd_valid_o, .cmd_op_o, .cmd_byte_o,
    .rsp_valid_i, .rsp_nack_i, .rsp_data_i, .rx_data_o
  );

  smb_seq_flags #(.FW(FLAG_W)) u_flags (
    .clk_i, .rst_ni,
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_vec)
  );

  assign flags      = flag_t'(flag_vec);
  assign mode_o     = flags.mode;
  assign xmit_o     = flags.xmit;
  assign data_rdy_o = flags.rdy;
  assign nack_o     = flags.nack;
  assign ber_o      = flags.ber;
  assign busy_o     = flags.busy;
  assign bus_held_o = flags.held;
  assign end_busy_o = flags.eob;
  assign stall_o    = flags.stall;

  // R10
  end_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_busy_o) |-> !cmd_valid_o);
endmodule

// File: tb/smb_seq_top_test.sv
module smb_seq_top_test;
  localparam int DW = 8;
  localparam int CW = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, data_wr_i = 0, data_rd_i = 0;
  logic nack_clr_i = 0, stall_clr_i = 0, stall_en_i = 0, fifo_en_i = 0;
  logic bus_busy_i = 0, rsp_valid_i = 0, rsp_nack_i = 0;
  logic [DW-1:0] wdata_i = '0, rsp_data_i = '0;
  logic [CW-1:0] fifo_cnt_i = '0;
  logic cmd_valid_o;
  logic [1:0] cmd_op_o;
  logic [DW-1:0] cmd_byte_o, rx_data_o;
  logic mode_o, xmit_o, data_rdy_o, nack_o, ber_o, busy_o, bus_held_o, end_busy_o, stall_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  smb_seq_top #(.DW(DW), .CW(CW)) uut (.*);

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; start_i = 0; stop_i = 0; data_wr_i = 0; data_rd_i = 0;
    nack_clr_i = 0; stall_clr_i = 0; stall_en_i = 0; fifo_en_i = 0;
    bus_busy_i = 0; rsp_valid_i = 0; rsp_nack_i = 0; fifo_cnt_i = '0;
    tick(); tick();
    rst_ni = 1;
    tick();
  endtask

  task automatic pulse_start(); start_i = 1; tick(); start_i = 0; endtask
  task automatic pulse_stop();  stop_i = 1;  tick(); stop_i = 0;  endtask
  task automatic pulse_rd();    data_rd_i = 1; tick(); data_rd_i = 0; endtask
  task automatic pulse_nclr();  nack_clr_i = 1; tick(); nack_clr_i = 0; endtask
  task automatic pulse_sclr();  stall_clr_i = 1; tick(); stall_clr_i = 0; endtask
  task automatic pulse_wr(input logic [7:0] b);
    wdata_i = b; data_wr_i = 1; tick(); data_wr_i = 0;
  endtask

  // check the pending command, then answer it one cycle later
  task automatic agent(input string tag, input logic [1:0] op, input logic [7:0] b,
                       input logic use_b, input logic nk, input logic [7:0] d);
    chk({tag, " cmd_valid"}, cmd_valid_o, 1);
    chk({tag, " cmd_op"}, cmd_op_o, op);
    if (use_b) chk({tag, " cmd_byte"}, cmd_byte_o, b);
    tick();
    chk({tag, " pulse one cycle"}, cmd_valid_o, 0);
    rsp_valid_i = 1; rsp_nack_i = nk; rsp_data_i = d;
    tick();
    rsp_valid_i = 0; rsp_nack_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flags", {mode_o, xmit_o, data_rdy_o, nack_o, ber_o, busy_o,
                     bus_held_o, end_busy_o, stall_o}, 0);
    chk("R1 cmd", cmd_valid_o, 0);
    pulse_stop();
    chk("R10 stop without mode", cmd_valid_o, 0);
  endtask

  task automatic t_start_fail();
    do_reset();
    bus_busy_i = 1;
    pulse_start();
    chk("R3 ber", ber_o, 1);
    chk("R3 mode", mode_o, 0);
    chk("R3 busy", busy_o, 0);
    chk("R3 held", bus_held_o, 1);
    pulse_wr(8'hA4);
    chk("R4 no addr without mode", cmd_valid_o, 0);
  endtask

  task automatic t_write_xfer();
    do_reset();
    pulse_start();
    chk("R2 flags", {mode_o, xmit_o, data_rdy_o, busy_o, bus_held_o}, 5'h1f);
    pulse_wr(8'hA4);
    agent("R4 addr write", 2'd0, 8'hA4, 1, 0, 8'h00);
    chk("R6 write xmit", xmit_o, 1);
    chk("R6 write rdy", data_rdy_o, 1);
    chk("R6 nack clear", nack_o, 0);
    pulse_wr(8'h3C);
    chk("R12 send cmd", cmd_valid_o, 1);
    chk("R12 send op", cmd_op_o, 2'd1);
    chk("R12 rdy low while sending", data_rdy_o, 0);
    stop_i = 1; tick(); stop_i = 0;
    chk("R12 stop ignored while waiting", cmd_valid_o, 0);
    rsp_valid_i = 1; tick(); rsp_valid_i = 0;
    chk("R12 rdy after ack", data_rdy_o, 1);
    chk("R12 no stray cmd", cmd_valid_o, 0);
    bus_busy_i = 1;
    pulse_start();
    chk("R2 repeated start mode", mode_o, 1);
    chk("R2 repeated start ber", ber_o, 0);
    bus_busy_i = 0;
    pulse_stop();
    agent("R10 end", 2'd3, 8'h00, 0, 0, 8'h00);
    chk("R10 eob", end_busy_o, 1);
    chk("R10 cleared", {mode_o, xmit_o, data_rdy_o, nack_o, busy_o, bus_held_o}, 0);
  endtask

  task automatic t_read_xfer();
    do_reset();
    pulse_start();
    pulse_wr(8'hA5);
    agent("R4 addr read", 2'd0, 8'hA5, 1, 0, 8'h00);
    chk("R6 read xmit", xmit_o, 0);
    agent("R6 recv", 2'd2, 8'h00, 0, 0, 8'h5A);
    chk("R6 rx data", rx_data_o, 8'h5A);
    chk("R6 rx rdy", data_rdy_o, 1);
    pulse_rd();
    agent("R6 next recv", 2'd2, 8'h00, 0, 0, 8'h77);
    chk("R6 rx data 2", rx_data_o, 8'h77);
    pulse_wr(8'h11);
    chk("R11 write while receiving", cmd_valid_o, 0);
    pulse_stop();
    chk("R8 stop deferred", cmd_valid_o, 0);
    chk("R8 still mode", mode_o, 1);
    pulse_rd();
    agent("R8 end on read", 2'd3, 8'h00, 0, 0, 8'h00);
    chk("R8 eob", end_busy_o, 1);
    chk("R8 mode off", mode_o, 0);
  endtask

  task automatic t_nack();
    do_reset();
    pulse_start();
    pulse_wr(8'h91);
    agent("R5 addr", 2'd0, 8'h91, 1, 1, 8'h00);
    chk("R5 nack", nack_o, 1);
    chk("R5 rdy", data_rdy_o, 0);
    chk("R5 xmit read", xmit_o, 0);
    pulse_wr(8'h11);
    chk("R11 write in nack", cmd_valid_o, 0);
    pulse_stop();
    chk("R9 stop deferred", cmd_valid_o, 0);
    pulse_nclr();
    agent("R9 end on clear", 2'd3, 8'h00, 0, 0, 8'h00);
    chk("R9 eob", end_busy_o, 1);
    // rejected data byte
    do_reset();
    pulse_start();
    pulse_wr(8'hA4);
    agent("R5 addr w", 2'd0, 8'hA4, 1, 0, 8'h00);
    pulse_wr(8'h22);
    agent("R5 data", 2'd1, 8'h22, 1, 1, 8'h00);
    chk("R5 data nack", nack_o, 1);
    chk("R5 data xmit", xmit_o, 1);
    chk("R5 data rdy", data_rdy_o, 0);
  endtask

  task automatic t_stall();
    do_reset();
    stall_en_i = 1;
    pulse_start();
    pulse_wr(8'hA5);
    agent("R7 addr", 2'd0, 8'hA5, 1, 0, 8'h00);
    chk("R7 stall", stall_o, 1);
    chk("R7 no recv", cmd_valid_o, 0);
    tick();
    chk("R7 still no recv", cmd_valid_o, 0);
    pulse_sclr();
    chk("R7 stall cleared", stall_o, 0);
    agent("R7 recv", 2'd2, 8'h00, 0, 0, 8'hC3);
    chk("R7 rx", rx_data_o, 8'hC3);
  endtask

  task automatic t_fifo_stop();
    do_reset();
    fifo_en_i = 1;
    pulse_start();
    pulse_wr(8'hA5);
    agent("R8 fifo addr", 2'd0, 8'hA5, 1, 0, 8'h00);
    agent("R8 fifo recv", 2'd2, 8'h00, 0, 0, 8'h01);
    fifo_cnt_i = 5'd3;
    pulse_rd();
    chk("R8 fifo read no cmd", cmd_valid_o, 0);
    pulse_stop();
    pulse_rd();
    chk("R8 fifo cnt 3 no stop", cmd_valid_o, 0);
    fifo_cnt_i = 5'd1;
    pulse_rd();
    agent("R8 fifo end", 2'd3, 8'h00, 0, 0, 8'h00);
    chk("R8 fifo eob", end_busy_o, 1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_start_fail();
    t_write_xfer();
    t_read_xfer();
    t_nack();
    t_stall();
    t_fifo_stop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule